// File: doc/BRIEF.md
# Two-Word Register-Machine Processor Core

This block is a small multi-cycle 32-bit processor. It reads fixed-width 32-bit instruction words from a word-addressed program memory and runs them against a file of 32 general registers. Each instruction word carries an opcode byte and three register-index bytes. Jumps, the immediate load and the conditional branches take a second word that holds a 32-bit constant or an absolute word address. Every register-to-register operation is a single three-operand word. A conditional branch compares two named registers directly, with no flags register.

The core drives a program-memory read address and expects the instruction word back in the same cycle. It also drives a single-port data-memory interface with address, write data and a write strobe, and its read data is expected back combinationally. A debug port shows the program counter and any one register chosen by a select input. The debug port never stalls or halts the core, so a test environment can observe results while the program runs.

Top module: `regcpu_core`

## Requirements
- R1: While `rst_n` is low, the program counter is 0, `imem_addr` is 0, `dmem_wr_en` is low, and every register reads 0.
- R2: In an instruction word, the opcode is in bits 31:24, the destination/first index is in bits 23:16, the second index is in bits 15:8 and the third index is in bits 7:0. Only the low 5 bits of each index byte select a register.
- R3: A single-word instruction takes two cycles (fetch, execute). A two-word instruction takes three cycles (fetch, second-word fetch, execute). `imem_addr` equals PC during the fetch and PC+1 during the second-word fetch. PC changes only at the end of the execute cycle.
- R4: Opcode 8 (immediate load) writes the second word into r[first] and advances PC by 2.
- R5: The register operations write r[first] and advance PC by 1. Opcode 12 shifts r[second] left and opcode 13 shifts it right (logical), in both cases by the low 5 bits of r[third]. The bitwise operations are AND (15), OR (16) and XOR (17) of r[second] and r[third]. Opcode 18 adds r[second] and r[third] modulo 2^32. Opcode 14 writes the bitwise inverse of r[second].
- R6: Opcode 1 loads PC with the second word unconditionally.
- R7: Opcodes 2 to 7 compare r[first] with r[second] as unsigned numbers, testing equal (2), not equal (3), greater (4), greater-or-equal (5), less (6) or less-or-equal (7). When the test holds, PC loads the second word. Otherwise PC advances by 2.
- R8: Opcode 11 makes one single-cycle write of r[second] to data address r[first], writes no register, and advances PC by 1.
- R9: Opcode 10 loads r[first] from data address r[second] and advances PC by 1.
- R10: Opcode 0, and every opcode not listed above (9 and 19 to 255), changes no register and no memory, and advances PC by 1.
- R11: `dbg_pc` always shows the current PC, and `dbg_reg` shows r[`dbg_sel`] in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| imem_addr | output | 32 | Program-memory word address |
| imem_rdata | input | 32 | Program word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data-memory word address |
| dmem_wdata | output | 32 | Data-memory write data |
| dmem_wr_en | output | 1 | Data-memory write strobe, one cycle per store |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |
| dbg_sel | input | 5 | Register index shown on `dbg_reg` |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg | output | 32 | Contents of the selected register |

## Verification
A wrong phase register or a wrong second-word decode shows up within one cycle on `imem_addr`: the address either fails to step to PC+1 or steps when it should not. Errors in PC sequencing, such as a branch taken the wrong way or an advance of 1 instead of 2, show on `dbg_pc` at the next execute boundary. They then cascade, because the core decodes the wrong words, so every register checked afterwards disagrees with the value expected. Register-file and ALU faults stay latent until a register is read through the debug port or stored to data memory. For that reason each scenario ends in a self-loop and then reads every destination register.

// File: rtl/regcpu_pkg.sv
package regcpu_pkg;

  // opcode byte values (instruction bits 31:24)
  localparam logic [7:0] OP_NOP = 8'd0;
  localparam logic [7:0] OP_JMP = 8'd1;
  localparam logic [7:0] OP_JEQ = 8'd2;
  localparam logic [7:0] OP_JNE = 8'd3;
  localparam logic [7:0] OP_JGT = 8'd4;
  localparam logic [7:0] OP_JGE = 8'd5;
  localparam logic [7:0] OP_JLT = 8'd6;
  localparam logic [7:0] OP_JLE = 8'd7;
  localparam logic [7:0] OP_MOV = 8'd8;
  localparam logic [7:0] OP_LDA = 8'd10;
  localparam logic [7:0] OP_STO = 8'd11;
  localparam logic [7:0] OP_SHL = 8'd12;
  localparam logic [7:0] OP_SHR = 8'd13;
  localparam logic [7:0] OP_NOT = 8'd14;
  localparam logic [7:0] OP_AND = 8'd15;
  localparam logic [7:0] OP_OR  = 8'd16;
  localparam logic [7:0] OP_XOR = 8'd17;
  localparam logic [7:0] OP_ADD = 8'd18;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_WORD2  = 2'd1,
    PH_EXEC   = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    WSRC_ALU = 2'd0,
    WSRC_IMM = 2'd1,
    WSRC_MEM = 2'd2
  } wsrc_e;

  // instructions carrying a second word: JMP, the six branches and MOV
  function automatic logic has_word2(input logic [7:0] op);
    return (op >= OP_JMP) && (op <= OP_MOV);
  endfunction

  function automatic logic is_branch(input logic [7:0] op);
    return (op >= OP_JEQ) && (op <= OP_JLE);
  endfunction

  function automatic logic is_alu_op(input logic [7:0] op);
    return (op >= OP_SHL) && (op <= OP_ADD);
  endfunction

endpackage

// File: rtl/regcpu_regfile.sv
module regcpu_regfile
  import regcpu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRD  = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [XLEN-1:0]                wr_data_i,
  input  logic [NRD-1:0][IDX_W-1:0]      rd_idx_i,
  output logic [NRD-1:0][XLEN-1:0]       rd_data_o
);

  logic [NREG-1:0][XLEN-1:0] bank;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic            hit;
    logic [XLEN-1:0] val_q;
    logic [XLEN-1:0] val_d;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_comb begin
      val_d = val_q;
      if (hit) val_d = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign bank[g] = val_q;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    assign rd_data_o[p] = bank[rd_idx_i[p]];
  end

  // a write must be visible on the next cycle (R5 / R4 destination update)
  assert_wr_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> bank[$past(wr_idx_i)] == $past(wr_data_i));

endmodule

// File: rtl/regcpu_alu.sv
module regcpu_alu
  import regcpu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [7:0]      op_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [XLEN-1:0] cmp_l_i,
  input  logic [XLEN-1:0] cmp_r_i,
  output logic [XLEN-1:0] result_o,
  output logic            take_o
);

  logic [SHW-1:0] shamt;
  logic           same;
  logic           below;

  assign shamt = src_b_i[SHW-1:0];
  assign same  = (cmp_l_i == cmp_r_i);
  assign below = (cmp_l_i <  cmp_r_i);

  always_comb begin
    unique case (op_i)
      OP_SHL:  result_o = src_a_i << shamt;
      OP_SHR:  result_o = src_a_i >> shamt;
      OP_NOT:  result_o = ~src_a_i;
      OP_AND:  result_o = src_a_i & src_b_i;
      OP_OR:   result_o = src_a_i | src_b_i;
      OP_XOR:  result_o = src_a_i ^ src_b_i;
      OP_ADD:  result_o = src_a_i + src_b_i;
      default: result_o = src_a_i;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_JEQ:  take_o = same;
      OP_JNE:  take_o = !same;
      OP_JGT:  take_o = !same && !below;
      OP_JGE:  take_o = !below;
      OP_JLT:  take_o = below;
      OP_JLE:  take_o = below || same;
      default: take_o = 1'b0;
    endcase
  end

  // R7: a branch verdict is never raised for a non-branch opcode
  always_comb begin
    assert_take_branch_only_R7: assert (!take_o || is_branch(op_i));
  end

endmodule

// File: rtl/regcpu_ctrl.sv
module regcpu_ctrl
  import regcpu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  imem_rdata_i,
  input  logic             take_i,
  output logic [XLEN-1:0]  imem_addr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [7:0]       op_o,
  output logic [IDX_W-1:0] fa_o,
  output logic [IDX_W-1:0] fb_o,
  output logic [IDX_W-1:0] fc_o,
  output logic [XLEN-1:0]  imm_o,
  output logic             rf_we_o,
  output wsrc_e            wsrc_o,
  output logic             dmem_we_o
);

  localparam logic [XLEN-1:0] STEP1 = XLEN'(1);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(2);

  phase_e           phase_q, phase_d;
  logic [XLEN-1:0]  pc_q, pc_d;
  logic [7:0]       op_q;
  logic [IDX_W-1:0] fa_q, fb_q, fc_q;
  logic [XLEN-1:0]  imm_q;
  logic             ir_en;
  logic             imm_en;
  logic             in_exec;

  logic unused_fields;
  assign unused_fields = ^{imem_rdata_i[23:16+IDX_W],
                           imem_rdata_i[15:8+IDX_W],
                           imem_rdata_i[7:IDX_W]};

  assign in_exec = (phase_q == PH_EXEC);

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    pc_d    = pc_q;
    ir_en   = 1'b0;
    imm_en  = 1'b0;
    unique case (phase_q)
      PH_FETCH: begin
        ir_en   = 1'b1;
        phase_d = has_word2(imem_rdata_i[31:24]) ? PH_WORD2 : PH_EXEC;
      end
      PH_WORD2: begin
        imm_en  = 1'b1;
        phase_d = PH_EXEC;
      end
      PH_EXEC: begin
        phase_d = PH_FETCH;
        if (op_q == OP_JMP)       pc_d = imm_q;
        else if (is_branch(op_q)) pc_d = take_i ? imm_q : (pc_q + STEP2);
        else if (op_q == OP_MOV)  pc_d = pc_q + STEP2;
        else                      pc_d = pc_q + STEP1;
      end
      default: phase_d = PH_FETCH;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
    end else begin
      phase_q <= phase_d;
      pc_q    <= pc_d;
    end
  end

  // instruction fields, clock-enabled in the fetch cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_NOP;
      fa_q <= '0;
      fb_q <= '0;
      fc_q <= '0;
    end else if (ir_en) begin
      op_q <= imem_rdata_i[31:24];
      fa_q <= imem_rdata_i[16 +: IDX_W];
      fb_q <= imem_rdata_i[8 +: IDX_W];
      fc_q <= imem_rdata_i[0 +: IDX_W];
    end
  end

  // second word, clock-enabled in the second-word fetch cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      imm_q <= '0;
    else if (imm_en) imm_q <= imem_rdata_i;
  end

  // write-back decode
  always_comb begin
    rf_we_o   = 1'b0;
    wsrc_o    = WSRC_ALU;
    dmem_we_o = 1'b0;
    if (in_exec) begin
      if (op_q == OP_MOV) begin
        rf_we_o = 1'b1;
        wsrc_o  = WSRC_IMM;
      end else if (op_q == OP_LDA) begin
        rf_we_o = 1'b1;
        wsrc_o  = WSRC_MEM;
      end else if (is_alu_op(op_q)) begin
        rf_we_o = 1'b1;
      end else if (op_q == OP_STO) begin
        dmem_we_o = 1'b1;
      end
    end
  end

  assign imem_addr_o = (phase_q == PH_WORD2) ? (pc_q + STEP1) : pc_q;
  assign pc_o        = pc_q;
  assign op_o        = op_q;
  assign fa_o        = fa_q;
  assign fb_o        = fb_q;
  assign fc_o        = fc_q;
  assign imm_o       = imm_q;

  assert_word2_then_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_WORD2 |=> phase_q == PH_EXEC);

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_exec |=> $stable(pc_q));

  assert_mov_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && op_q == OP_MOV) |=> pc_q == $past(pc_q) + STEP2);

  assert_jmp_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && op_q == OP_JMP) |=> pc_q == $past(imm_q));

  assert_plain_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && (op_q == OP_NOP || op_q > OP_MOV)) |=> pc_q == $past(pc_q) + STEP1);

endmodule

// File: rtl/regcpu_core.sv
module regcpu_core
  import regcpu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int NRD   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [XLEN-1:0]  imem_addr,
  input  logic [XLEN-1:0]  imem_rdata,
  output logic [XLEN-1:0]  dmem_addr,
  output logic [XLEN-1:0]  dmem_wdata,
  output logic             dmem_wr_en,
  input  logic [XLEN-1:0]  dmem_rdata,
  input  logic [IDX_W-1:0] dbg_sel,
  output logic [XLEN-1:0]  dbg_pc,
  output logic [XLEN-1:0]  dbg_reg
);

  localparam int RP_A   = 0;
  localparam int RP_B   = 1;
  localparam int RP_C   = 2;
  localparam int RP_DBG = 3;

  logic [7:0]                op;
  logic [IDX_W-1:0]          fa, fb, fc;
  logic [XLEN-1:0]           imm;
  logic                      rf_we;
  wsrc_e                     wsrc;
  logic                      take;
  logic [XLEN-1:0]           alu_res;
  logic [XLEN-1:0]           wr_data;
  logic [NRD-1:0][IDX_W-1:0] rd_idx;
  logic [NRD-1:0][XLEN-1:0]  rd_data;

  regcpu_ctrl #(.XLEN(XLEN), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .imem_rdata_i (imem_rdata),
    .take_i       (take),
    .imem_addr_o  (imem_addr),
    .pc_o         (dbg_pc),
    .op_o         (op),
    .fa_o         (fa),
    .fb_o         (fb),
    .fc_o         (fc),
    .imm_o        (imm),
    .rf_we_o      (rf_we),
    .wsrc_o       (wsrc),
    .dmem_we_o    (dmem_wr_en)
  );

  assign rd_idx[RP_A]   = fa;
  assign rd_idx[RP_B]   = fb;
  assign rd_idx[RP_C]   = fc;
  assign rd_idx[RP_DBG] = dbg_sel;

  regcpu_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (rf_we),
    .wr_idx_i  (fa),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  regcpu_alu #(.XLEN(XLEN)) u_alu (
    .op_i     (op),
    .src_a_i  (rd_data[RP_B]),
    .src_b_i  (rd_data[RP_C]),
    .cmp_l_i  (rd_data[RP_A]),
    .cmp_r_i  (rd_data[RP_B]),
    .result_o (alu_res),
    .take_o   (take)
  );

  always_comb begin
    unique case (wsrc)
      WSRC_IMM: wr_data = imm;
      WSRC_MEM: wr_data = dmem_rdata;
      default:  wr_data = alu_res;
    endcase
  end

  // store addresses through r[first], load through r[second]
  assign dmem_addr  = (op == OP_STO) ? rd_data[RP_A] : rd_data[RP_B];
  assign dmem_wdata = rd_data[RP_B];
  assign dbg_reg    = rd_data[RP_DBG];

  assert_store_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr_en |=> !dmem_wr_en);

  assert_store_no_rf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr_en |-> !rf_we);

  assert_fetch_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || dmem_wr_en) |=> imem_addr == dbg_pc);

endmodule

// File: tb/regcpu_core_tb.sv
module regcpu_core_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_wr_en;
  logic [4:0]  dbg_sel;
  logic [31:0] dbg_pc, dbg_reg;

  logic [31:0] prog [256];
  logic [31:0] dmem [256];
  int          we_count;
  int          checks = 0;
  int          errors = 0;

  regcpu_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_wr_en (dmem_wr_en),
    .dmem_rdata (dmem_rdata),
    .dbg_sel    (dbg_sel),
    .dbg_pc     (dbg_pc),
    .dbg_reg    (dbg_reg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_rdata = prog[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];

  always @(posedge clk) begin
    if (dmem_wr_en) begin
      dmem[dmem_addr[7:0]] <= dmem_wdata;
      we_count <= we_count + 1;
    end
  end

  function automatic logic [31:0] ins(input int op, input int a, input int b, input int c);
    return {8'(op), 8'(a), 8'(b), 8'(c)};
  endfunction

  function automatic bit cond_holds(input int op, input logic [31:0] x, input logic [31:0] y);
    case (op)
      2: return x == y;
      3: return x != y;
      4: return x > y;
      5: return x >= y;
      6: return x < y;
      7: return x <= y;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic getreg(input int idx, output logic [31:0] val);
    dbg_sel = 5'(idx);
    #1;
    val = dbg_reg;
  endtask

  // hold reset, wipe memories, program loaded by caller afterwards
  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      prog[i] = 32'd0;
      dmem[i] <= 32'd0;
    end
    we_count <= 0;
    run(2);
  endtask

  task automatic leave_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    // leave a nonzero value in r3 first, then reset again
    enter_reset();
    prog[0] = ins(8, 3, 0, 0); prog[1] = 32'h0BAD_BEEF;
    prog[2] = ins(1, 0, 0, 0); prog[3] = 32'd2;
    leave_reset();
    run(12);
    getreg(3, v);
    chk("R4", "r3 before reset", v, 32'h0BAD_BEEF);
    enter_reset();
    chk("R1", "pc in reset", dbg_pc, 32'd0);
    chk("R1", "imem_addr in reset", imem_addr, 32'd0);
    chk("R1", "dmem_wr_en in reset", {31'd0, dmem_wr_en}, 32'd0);
    getreg(3, v);
    chk("R1", "r3 cleared by reset", v, 32'd0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    enter_reset();
    prog[0] = ins(0, 0, 0, 0);
    prog[1] = ins(8, 1, 0, 0); prog[2] = 32'd7;
    prog[3] = ins(1, 0, 0, 0); prog[4] = 32'd3;
    leave_reset();
    chk("R3", "fetch addr cycle 0", imem_addr, 32'd0);
    run(1);
    chk("R3", "pc held in exec", dbg_pc, 32'd0);
    run(1);
    chk("R3", "pc after 1-word op", dbg_pc, 32'd1);
    chk("R3", "fetch addr of MOV", imem_addr, 32'd1);
    run(1);
    chk("R3", "second-word addr", imem_addr, 32'd2);
    run(1);
    getreg(1, v);
    chk("R3", "r1 not yet written", v, 32'd0);
    chk("R3", "pc before MOV exec", dbg_pc, 32'd1);
    run(1);
    getreg(1, v);
    chk("R4", "r1 after MOV", v, 32'd7);
    chk("R4", "pc after MOV", dbg_pc, 32'd3);
    chk("R11", "dbg_pc equals fetch addr", dbg_pc, imem_addr);
  endtask

  task automatic t_regops();
    logic [31:0] v;
    enter_reset();
    prog[0]  = ins(8, 1, 0, 0);   prog[1] = 32'h8000_0001;
    prog[2]  = ins(8, 2, 0, 0);   prog[3] = 32'd36;
    prog[4]  = ins(8, 3, 0, 0);   prog[5] = 32'hFFFF_FFFF;
    prog[6]  = ins(8, 4, 0, 0);   prog[7] = 32'd1;
    prog[8]  = ins(12, 5, 1, 2);
    prog[9]  = ins(13, 6, 1, 2);
    prog[10] = ins(18, 7, 3, 4);
    prog[11] = ins(17, 8, 1, 3);
    prog[12] = ins(15, 9, 1, 3);
    prog[13] = ins(16, 10, 4, 2);
    prog[14] = ins(14, 11, 1, 0);
    prog[15] = ins(18, 8'h2C, 8'h21, 8'h24);  // index bytes above 31: low 5 bits used
    prog[16] = ins(1, 0, 0, 0);   prog[17] = 32'd16;
    leave_reset();
    run(80);
    getreg(5, v);  chk("R5", "SHL by low 5 bits of 36", v, 32'h0000_0010);
    getreg(6, v);  chk("R5", "SHR logical", v, 32'h0800_0000);
    getreg(7, v);  chk("R5", "ADD wraps", v, 32'd0);
    getreg(8, v);  chk("R5", "XOR", v, 32'h7FFF_FFFE);
    getreg(9, v);  chk("R5", "AND", v, 32'h8000_0001);
    getreg(10, v); chk("R5", "OR", v, 32'h0000_0025);
    getreg(11, v); chk("R5", "NOT", v, 32'h7FFF_FFFE);
    getreg(12, v); chk("R2", "index bytes truncated to 5 bits", v, 32'h8000_0002);
    chk("R6", "self-loop pc", dbg_pc, 32'd16);
  endtask

  task automatic t_jump();
    logic [31:0] v;
    enter_reset();
    prog[0] = ins(1, 0, 0, 0); prog[1] = 32'd5;
    prog[2] = ins(8, 1, 0, 0); prog[3] = 32'd1;
    prog[5] = ins(8, 2, 0, 0); prog[6] = 32'd2;
    prog[7] = ins(1, 0, 0, 0); prog[8] = 32'd7;
    leave_reset();
    run(30);
    getreg(1, v); chk("R6", "skipped MOV left r1", v, 32'd0);
    getreg(2, v); chk("R6", "target MOV ran", v, 32'd2);
    chk("R6", "pc at loop", dbg_pc, 32'd7);
  endtask

  task automatic t_branch(input int op, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] v;
    bit          tk;
    string       tag;
    tk = cond_holds(op, x, y);
    enter_reset();
    prog[0]  = ins(8, 1, 0, 0);  prog[1]  = x;
    prog[2]  = ins(8, 2, 0, 0);  prog[3]  = y;
    prog[4]  = ins(op, 1, 2, 0); prog[5]  = 32'd10;
    prog[6]  = ins(8, 3, 0, 0);  prog[7]  = 32'h111;
    prog[8]  = ins(1, 0, 0, 0);  prog[9]  = 32'd8;
    prog[10] = ins(8, 3, 0, 0);  prog[11] = 32'h222;
    prog[12] = ins(1, 0, 0, 0);  prog[13] = 32'd12;
    leave_reset();
    run(40);
    tag = $sformatf("op %0d x=%h y=%h", op, x, y);
    getreg(3, v);
    chk("R7", {tag, " path"}, v, tk ? 32'h222 : 32'h111);
    chk("R7", {tag, " pc"}, dbg_pc, tk ? 32'd12 : 32'd8);
  endtask

  task automatic t_mem();
    logic [31:0] v;
    enter_reset();
    prog[0]  = ins(8, 1, 0, 0);  prog[1] = 32'd20;
    prog[2]  = ins(8, 2, 0, 0);  prog[3] = 32'hCAFE_F00D;
    prog[4]  = ins(11, 1, 2, 0);
    prog[5]  = ins(8, 3, 0, 0);  prog[6] = 32'd21;
    prog[7]  = ins(10, 4, 3, 0);
    prog[8]  = ins(10, 5, 1, 0);
    prog[9]  = ins(1, 0, 0, 0);  prog[10] = 32'd9;
    dmem[21] <= 32'h1234_5678;
    leave_reset();
    run(40);
    chk("R8", "stored word", dmem[20], 32'hCAFE_F00D);
    chk("R8", "exactly one write", 32'(we_count), 32'd1);
    getreg(1, v); chk("R8", "address reg untouched", v, 32'd20);
    getreg(4, v); chk("R9", "load preset word", v, 32'h1234_5678);
    getreg(5, v); chk("R9", "load stored word", v, 32'hCAFE_F00D);
    chk("R9", "pc at loop", dbg_pc, 32'd9);
  endtask

  task automatic t_nop();
    logic [31:0] v;
    enter_reset();
    prog[0] = ins(8, 1, 0, 0);  prog[1] = 32'd5;
    prog[2] = ins(9, 1, 1, 1);
    prog[3] = ins(8'h40, 1, 1, 1);
    prog[4] = ins(0, 1, 1, 1);
    prog[5] = ins(19, 2, 1, 1);
    prog[6] = ins(1, 0, 0, 0);  prog[7] = 32'd6;
    leave_reset();
    run(5);
    chk("R10", "undefined op 9 step", dbg_pc, 32'd3);
    run(35);
    getreg(1, v); chk("R10", "r1 unchanged", v, 32'd5);
    getreg(2, v); chk("R10", "r2 unchanged", v, 32'd0);
    chk("R10", "no memory write", 32'(we_count), 32'd0);
    chk("R10", "pc reached loop", dbg_pc, 32'd6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    dbg_sel  = 5'd0;
    we_count = 0;
    t_reset();
    t_timing();
    t_regops();
    t_jump();
    t_branch(2, 32'd9, 32'd9);
    t_branch(2, 32'd9, 32'd8);
    t_branch(3, 32'd9, 32'd8);
    t_branch(3, 32'd4, 32'd4);
    t_branch(4, 32'hFFFF_FFFF, 32'd1);
    t_branch(4, 32'd6, 32'd6);
    t_branch(5, 32'd6, 32'd6);
    t_branch(5, 32'd1, 32'hFFFF_FFFF);
    t_branch(6, 32'd1, 32'hFFFF_FFFF);
    t_branch(6, 32'd7, 32'd3);
    t_branch(7, 32'd3, 32'd3);
    t_branch(7, 32'h8000_0000, 32'd3);
    t_mem();
    t_nop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule